// File: doc/BRIEF.md
# Power Management Fixed Register Block

This block is a small byte-wide I/O register file that holds the fixed power-management hardware of a system controller: an event status word with its wake/interrupt enables, a control word that carries a sleep request, a free-running timer, a general-purpose event status word and a global status/enable/control trio that drives the system-management interrupt. Software reaches every register one byte at a time through a 6-bit byte address. Wider registers are spread over consecutive byte offsets, and the low address bits pick the byte lane.

Hardware events enter on two 16-bit set buses and a timer tick enable. The block produces four outputs. The first is a level interrupt, raised whenever an enabled status event is pending. The second is a one-cycle system-management pulse, raised when firmware sets the global-release control bit while the matching global enable is on. The third and fourth are two latched requests, soft power-off and suspend-to-RAM. A sleep-enable write with the right sleep type raises one of these two requests, and the surrounding power sequencer acts on it.

Top module: `pwrmgmt_regs`

## Requirements
- R1: Writes take effect at the clock edge where `wr_i` is high, and a read of address A returns its byte on `rdata_o` from the edge where `rd_i` is high. For 16-bit registers, address bit 0 selects the byte: 0 is bits 7:0 and 1 is bits 15:8. For the timer, address bits 1:0 select the byte. Byte offsets 0x06, 0x07, 0x0E, 0x0F, 0x16 and above read 0x00.
- R2: The event status word (offsets 0x00/0x01) keeps only the bits in mask 0x8D31. A bit sets when the matching `sts_set_i` bit is high. Writing 1 to a bit clears it and writing 0 has no effect. A set event wins over a clear in the same cycle.
- R3: The enable word (offsets 0x02/0x03) is read/write. It stores only the bits in mask 0x0521, and all other bits read 0.
- R4: `sci_o` is high exactly when some bit is set in both the event status word and the enable word. It follows each write or event on the next clock edge.
- R5: The control word (offsets 0x04/0x05) is read/write and stores only the bits in mask 0x3C07.
- R6: A write to offset 0x04 that leaves control bit 2 set also sets bit 5 of the global status word (offset 0x10/0x11, write-1-to-clear, mask 0x0020). If bit 5 of the global enable word (offset 0x12/0x13, read/write, mask 0x0020) is set at the same time, `smi_o` is high for exactly the next cycle. A write to offset 0x05 never does either.
- R7: After a write to offset 0x04 or 0x05, the block looks at the control word. If control bit 13 (sleep enable) is set, the sleep type in bits 12:10 is decoded. Type 0 latches `soft_off_o` and type 1 latches `susp_ram_o`. Other types have no effect. Both outputs stay high until reset.
- R8: The global control word (offset 0x14/0x15) is read/write and stores only mask 0x0002. After any write to offset 0x00 that leaves event status bit 5 clear, global control bit 1 is cleared.
- R9: The timer is a TMR_W-bit counter (default 24). It counts up by one on each cycle with `tick_i` high and wraps to zero. It reads at offsets 0x08 to 0x0B, and bits above TMR_W-1 read as 0. Writes to the timer are ignored.
- R10: When an increment toggles the timer's top bit, event status bit 0 sets.
- R11: The general-purpose status word (offsets 0x0C/0x0D) sets from `gp_set_i`, is write-1-to-clear, and keeps only the bits in mask 0x0F81.
- R12: After reset, every register reads 0 and all four outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 6 | Byte address |
| wdata_i | input | 8 | Write data byte |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| rdata_o | output | 8 | Registered read data |
| tick_i | input | 1 | Timer increment enable |
| sts_set_i | input | 16 | Event status set pulses |
| gp_set_i | input | 16 | General-purpose status set pulses |
| sci_o | output | 1 | Level interrupt for enabled pending events |
| smi_o | output | 1 | One-cycle system-management pulse |
| soft_off_o | output | 1 | Latched soft power-off request |
| susp_ram_o | output | 1 | Latched suspend-to-RAM request |

## Verification
The bench covers the following corner cases, each with the failure it would expose:
- A wrong clear or store mask leaves reserved bits readable, or leaves clearable bits stuck.
- Writing global release to the high control byte, or with the global enable off, must give no pulse. A design that decodes the wrong offset or ignores the enable fires the interrupt anyway.
- The global-control clear is tested both with event status bit 5 still set and with it just cleared. A design that tests the old status value keeps or drops the bit at the wrong write.
- The timer is driven across its top-bit toggle. A sleep type other than 0 or 1 must latch nothing, and a later soft-off request must leave the suspend request standing.

// File: rtl/pwrmgmt_pkg.sv
package pwrmgmt_pkg;
  localparam logic [15:0] STS_MASK  = 16'h8D31;
  localparam logic [15:0] EN_MASK   = 16'h0521;
  localparam logic [15:0] CTL_MASK  = 16'h3C07;
  localparam logic [15:0] GP_MASK   = 16'h0F81;
  localparam logic [15:0] GSTS_MASK = 16'h0020;
  localparam logic [15:0] GEN_MASK  = 16'h0020;
  localparam logic [15:0] GCTL_MASK = 16'h0002;

  localparam logic [5:0] OFS_STS  = 6'h00;
  localparam logic [5:0] OFS_EN   = 6'h02;
  localparam logic [5:0] OFS_CTL  = 6'h04;
  localparam logic [5:0] OFS_TMR  = 6'h08;
  localparam logic [5:0] OFS_GP   = 6'h0C;
  localparam logic [5:0] OFS_GSTS = 6'h10;
  localparam logic [5:0] OFS_GEN  = 6'h12;
  localparam logic [5:0] OFS_GCTL = 6'h14;

  localparam int CTL_GREL_BIT = 2;
  localparam int CTL_SLP_BIT  = 13;
  localparam int CTL_TYP_LSB  = 10;
  localparam int GLB_SMI_BIT  = 5;
  localparam int STS_GREL_BIT = 5;

  typedef enum logic [2:0] {
    SLP_SOFT_OFF = 3'd0,
    SLP_SUSP_RAM = 3'd1
  } slp_type_e;

  function automatic logic [15:0] lane_merge(logic [15:0] old, logic hi, logic [7:0] b);
    return hi ? {b, old[7:0]} : {old[15:8], b};
  endfunction
endpackage

// File: rtl/pm_timer.sv
module pm_timer #(
  parameter int W = 24
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  output logic [W-1:0] cnt_o,
  output logic         ovf_o
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_inc;

  assign cnt_inc = cnt_q + 1'b1;
  assign ovf_o   = tick_i & (cnt_inc[W-1] ^ cnt_q[W-1]);
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_inc;
  end

  // R9: counter holds when no tick
  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(tick_i) |-> $stable(cnt_q));
endmodule

// File: rtl/pm_w1c_reg.sv
module pm_w1c_reg #(
  parameter logic [15:0] MASK = 16'hFFFF
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_i,
  input  logic        hi_i,
  input  logic [7:0]  wdata_i,
  input  logic [15:0] set_i,
  output logic [15:0] q_o
);
  logic [15:0] q;
  logic [15:0] clr;

  assign clr = wr_i ? ((hi_i ? {wdata_i, 8'h00} : {8'h00, wdata_i}) & MASK) : 16'h0000;
  assign q_o = q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= (q & ~clr) | (set_i & MASK);
  end

  // R2/R11: a write-1 on bit 0 with no set event clears it
  a_r2_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !hi_i && wdata_i[0] && !set_i[0]) |=> !q[0]);
  a_r11_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i & MASK) == 16'h0000 |=> (q & ~$past(q)) == 16'h0000);
endmodule

// File: rtl/pm_rw_reg.sv
module pm_rw_reg #(
  parameter logic [15:0] MASK = 16'hFFFF
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_i,
  input  logic        hi_i,
  input  logic [7:0]  wdata_i,
  input  logic [15:0] clr_i,
  output logic [15:0] q_o
);
  import pwrmgmt_pkg::*;
  logic [15:0] q;
  logic [15:0] nxt;

  assign nxt = wr_i ? (lane_merge(q, hi_i, wdata_i) & MASK) : q;
  assign q_o = q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= nxt & ~clr_i;
  end

  // R3: without a write or clear the register holds
  a_r3_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_i && clr_i == 16'h0000) |=> $stable(q));
endmodule

// File: rtl/pm_sleep_dec.sv
module pm_sleep_dec (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ctl_wr_i,
  input  logic       slp_en_i,
  input  logic [2:0] slp_typ_i,
  output logic       soft_off_o,
  output logic       susp_ram_o
);
  import pwrmgmt_pkg::*;
  logic go;
  assign go = ctl_wr_i & slp_en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      soft_off_o <= 1'b0;
      susp_ram_o <= 1'b0;
    end else if (go) begin
      if (slp_typ_i == SLP_SOFT_OFF) soft_off_o <= 1'b1;
      if (slp_typ_i == SLP_SUSP_RAM) susp_ram_o <= 1'b1;
    end
  end

  // R7: requests are sticky
  a_r7_off_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_off_o |=> soft_off_o);
  a_r7_s2r_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    susp_ram_o |=> susp_ram_o);
endmodule

// File: rtl/pwrmgmt_regs.sv
module pwrmgmt_regs #(
  parameter int TMR_W = 24
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [5:0]  addr_i,
  input  logic [7:0]  wdata_i,
  input  logic        wr_i,
  input  logic        rd_i,
  output logic [7:0]  rdata_o,
  input  logic        tick_i,
  input  logic [15:0] sts_set_i,
  input  logic [15:0] gp_set_i,
  output logic        sci_o,
  output logic        smi_o,
  output logic        soft_off_o,
  output logic        susp_ram_o
);
  import pwrmgmt_pkg::*;

  localparam int TW = (TMR_W > 32) ? 32 : TMR_W;

  logic hi;
  logic wr_sts, wr_en, wr_ctl, wr_gp, wr_gsts, wr_gen, wr_gctl;
  logic [15:0] sts_q, en_q, ctl_q, ctl_nxt, gp_q, gsts_q, gen_q, gctl_q;
  logic [15:0] sts_set, gsts_set, gctl_clr;
  logic [TW-1:0] cnt;
  logic [31:0] tmr32;
  logic tmr_ovf, grel, sts5_after, smi_q;
  logic [7:0] rd_byte, rdata_q;

  assign hi = addr_i[0];
  assign wr_sts  = wr_i && addr_i[5:1] == OFS_STS[5:1];
  assign wr_en   = wr_i && addr_i[5:1] == OFS_EN[5:1];
  assign wr_ctl  = wr_i && addr_i[5:1] == OFS_CTL[5:1];
  assign wr_gp   = wr_i && addr_i[5:1] == OFS_GP[5:1];
  assign wr_gsts = wr_i && addr_i[5:1] == OFS_GSTS[5:1];
  assign wr_gen  = wr_i && addr_i[5:1] == OFS_GEN[5:1];
  assign wr_gctl = wr_i && addr_i[5:1] == OFS_GCTL[5:1];

  pm_timer #(.W(TW)) u_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .cnt_o(cnt), .ovf_o(tmr_ovf)
  );
  assign tmr32 = 32'(cnt);

  assign sts_set = sts_set_i | {15'b0, tmr_ovf};

  pm_w1c_reg #(.MASK(STS_MASK)) u_sts (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_sts), .hi_i(hi),
    .wdata_i(wdata_i), .set_i(sts_set), .q_o(sts_q)
  );

  pm_rw_reg #(.MASK(EN_MASK)) u_en (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_en), .hi_i(hi),
    .wdata_i(wdata_i), .clr_i(16'h0000), .q_o(en_q)
  );

  pm_w1c_reg #(.MASK(GP_MASK)) u_gp (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_gp), .hi_i(hi),
    .wdata_i(wdata_i), .set_i(gp_set_i), .q_o(gp_q)
  );

  // control word kept here: its next value feeds release and sleep decode
  assign ctl_nxt = wr_ctl ? (lane_merge(ctl_q, hi, wdata_i) & CTL_MASK) : ctl_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctl_q <= '0;
    else         ctl_q <= ctl_nxt;
  end

  assign grel = wr_ctl && !hi && ctl_nxt[CTL_GREL_BIT];
  assign gsts_set = grel ? 16'(1) << GLB_SMI_BIT : 16'h0000;

  pm_w1c_reg #(.MASK(GSTS_MASK)) u_gsts (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_gsts), .hi_i(hi),
    .wdata_i(wdata_i), .set_i(gsts_set), .q_o(gsts_q)
  );

  pm_rw_reg #(.MASK(GEN_MASK)) u_gen (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_gen), .hi_i(hi),
    .wdata_i(wdata_i), .clr_i(16'h0000), .q_o(gen_q)
  );

  // status bit 5 as it stands after this cycle's write and events
  assign sts5_after = (sts_q[STS_GREL_BIT] & ~(wr_sts & !hi & wdata_i[STS_GREL_BIT]))
                    | sts_set_i[STS_GREL_BIT];
  assign gctl_clr = (wr_sts && !hi && !sts5_after) ? GCTL_MASK : 16'h0000;

  pm_rw_reg #(.MASK(GCTL_MASK)) u_gctl (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_gctl), .hi_i(hi),
    .wdata_i(wdata_i), .clr_i(gctl_clr), .q_o(gctl_q)
  );

  pm_sleep_dec u_slp (
    .clk_i(clk_i), .rst_ni(rst_ni), .ctl_wr_i(wr_ctl),
    .slp_en_i(ctl_nxt[CTL_SLP_BIT]), .slp_typ_i(ctl_nxt[CTL_TYP_LSB +: 3]),
    .soft_off_o(soft_off_o), .susp_ram_o(susp_ram_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) smi_q <= 1'b0;
    else         smi_q <= grel & gen_q[GLB_SMI_BIT];
  end
  assign smi_o = smi_q;
  assign sci_o = |(sts_q & en_q);

  always_comb begin
    rd_byte = 8'h00;
    unique case (addr_i[5:1])
      OFS_STS[5:1]:  rd_byte = sts_q[{addr_i[0], 3'b000} +: 8];
      OFS_EN[5:1]:   rd_byte = en_q[{addr_i[0], 3'b000} +: 8];
      OFS_CTL[5:1]:  rd_byte = ctl_q[{addr_i[0], 3'b000} +: 8];
      OFS_GP[5:1]:   rd_byte = gp_q[{addr_i[0], 3'b000} +: 8];
      OFS_GSTS[5:1]: rd_byte = gsts_q[{addr_i[0], 3'b000} +: 8];
      OFS_GEN[5:1]:  rd_byte = gen_q[{addr_i[0], 3'b000} +: 8];
      OFS_GCTL[5:1]: rd_byte = gctl_q[{addr_i[0], 3'b000} +: 8];
      OFS_TMR[5:1], 5'(OFS_TMR[5:1] + 5'd1):
                     rd_byte = tmr32[{addr_i[1:0], 3'b000} +: 8];
      default:       rd_byte = 8'h00;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (rd_i) rdata_q <= rd_byte;
  end
  assign rdata_o = rdata_q;

  // R6: a pulse only follows a low-byte control write carrying release
  a_r6_smi_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smi_o |-> $past(wr_i && addr_i == OFS_CTL && wdata_i[CTL_GREL_BIT]));
  // R6: a release write with the enable on always gives the pulse
  a_r6_smi_fire: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == OFS_CTL && wdata_i[CTL_GREL_BIT] && gen_q[GLB_SMI_BIT]) |=> smi_o);
  // R8: the clear follows a status write that drops bit 5
  a_r8_gctl_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == OFS_STS && wdata_i[STS_GREL_BIT] && !sts_set_i[STS_GREL_BIT])
      |=> !gctl_q[1]);
  // R4: no pending enabled event means no interrupt
  a_r4_sci: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q == 16'h0000) |-> !sci_o);
endmodule

// File: tb/pwrmgmt_regs_tb_top.sv
module pwrmgmt_regs_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [5:0] addr = '0;
  logic [7:0] wdata = '0;
  logic wr = 1'b0, rd = 1'b0, tick = 1'b0;
  logic [15:0] sts_set = '0, gp_set = '0;
  logic [7:0] rdata;
  logic sci, smi, soft_off, susp_ram;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  pwrmgmt_regs #(.TMR_W(10)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata),
    .wr_i(wr), .rd_i(rd), .rdata_o(rdata), .tick_i(tick),
    .sts_set_i(sts_set), .gp_set_i(gp_set), .sci_o(sci), .smi_o(smi),
    .soft_off_o(soft_off), .susp_ram_o(susp_ram)
  );

  typedef struct {
    logic [5:0] a;
    logic [7:0] exp;
    string      tag;
  } rd_item_t;
  rd_item_t exp_q[$];
  logic rd_pend = 1'b0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) rd_pend <= rd;

  // monitor: compares read data one edge after the strobe
  always @(negedge clk) begin
    if (rd_pend && exp_q.size() > 0) begin
      rd_item_t it;
      it = exp_q.pop_front();
      check($sformatf("%s @%02h", it.tag, it.a), {24'h0, rdata}, {24'h0, it.exp});
    end
  end

  task automatic wr_b(input logic [5:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_exp(input logic [5:0] a, input logic [7:0] e, input string tag);
    rd_item_t it;
    it.a = a; it.exp = e; it.tag = tag;
    exp_q.push_back(it);
    addr = a; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic pulse_set(input logic [15:0] s, input logic [15:0] g);
    sts_set = s; gp_set = g;
    @(negedge clk);
    sts_set = '0; gp_set = '0;
  endtask

  task automatic ticks(input int n);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R12 reset state
    check("R12 sci", {31'b0, sci}, 0);
    check("R12 smi", {31'b0, smi}, 0);
    check("R12 soft_off", {31'b0, soft_off}, 0);
    check("R12 susp_ram", {31'b0, susp_ram}, 0);
    rd_exp(6'h00, 8'h00, "R12");
    rd_exp(6'h05, 8'h00, "R12");

    // R2 set and clear masks
    pulse_set(16'hFFFF, 16'h0000);
    rd_exp(6'h00, 8'h31, "R2 set lo");
    rd_exp(6'h01, 8'h8D, "R2 set hi");
    wr_b(6'h00, 8'h01);
    rd_exp(6'h00, 8'h30, "R2 w1c lo");
    wr_b(6'h01, 8'h0D);
    rd_exp(6'h01, 8'h80, "R2 w1c hi");
    wr_b(6'h00, 8'h00);
    rd_exp(6'h00, 8'h30, "R2 write0 no effect");

    // R3 enable mask
    wr_b(6'h02, 8'hFF);
    wr_b(6'h03, 8'hFF);
    rd_exp(6'h02, 8'h21, "R3 lo");
    rd_exp(6'h03, 8'h05, "R3 hi");

    // R4 interrupt level: status 0x8030 & enable 0x0521
    check("R4 sci on", {31'b0, sci}, 1);
    wr_b(6'h00, 8'h20);
    check("R4 sci off", {31'b0, sci}, 0);

    // R5 control mask, no release, no sleep
    wr_b(6'h04, 8'hFB);
    rd_exp(6'h04, 8'h03, "R5 lo");
    wr_b(6'h05, 8'hC3);
    rd_exp(6'h05, 8'h00, "R5 hi");
    check("R5 no smi", {31'b0, smi}, 0);

    // R6 global release
    wr_b(6'h12, 8'hFF);
    rd_exp(6'h12, 8'h20, "R6 gen mask");
    wr_b(6'h04, 8'h04);
    check("R6 smi pulse", {31'b0, smi}, 1);
    @(negedge clk);
    check("R6 smi one cycle", {31'b0, smi}, 0);
    rd_exp(6'h10, 8'h20, "R6 gsts set");
    wr_b(6'h10, 8'h20);
    rd_exp(6'h10, 8'h00, "R6 gsts w1c");
    wr_b(6'h05, 8'h00);
    wr_b(6'h05, 8'h04);
    check("R6 hi byte no smi", {31'b0, smi}, 0);
    rd_exp(6'h10, 8'h00, "R6 hi byte no gsts");
    wr_b(6'h12, 8'h00);
    wr_b(6'h04, 8'h04);
    check("R6 gen off no smi", {31'b0, smi}, 0);
    rd_exp(6'h10, 8'h20, "R6 gsts without gen");

    // R8 global control clear
    wr_b(6'h14, 8'hFF);
    rd_exp(6'h14, 8'h02, "R8 mask");
    wr_b(6'h00, 8'h00);
    rd_exp(6'h14, 8'h00, "R8 cleared bit5 low");
    pulse_set(16'h0020, 16'h0000);
    wr_b(6'h14, 8'h02);
    wr_b(6'h00, 8'h00);
    rd_exp(6'h14, 8'h02, "R8 kept bit5 high");
    wr_b(6'h00, 8'h20);
    rd_exp(6'h14, 8'h00, "R8 cleared by w1c");

    // R11 general-purpose status
    pulse_set(16'h0000, 16'hFFFF);
    rd_exp(6'h0C, 8'h81, "R11 lo");
    rd_exp(6'h0D, 8'h0F, "R11 hi");
    wr_b(6'h0C, 8'h80);
    rd_exp(6'h0C, 8'h01, "R11 w1c");

    // R1 unmapped offsets
    rd_exp(6'h06, 8'h00, "R1 unmapped");
    rd_exp(6'h0E, 8'h00, "R1 unmapped");
    rd_exp(6'h3F, 8'h00, "R1 unmapped");

    // R9 timer (TMR_W=10)
    wr_b(6'h00, 8'hFF);
    wr_b(6'h01, 8'hFF);
    ticks(300);
    rd_exp(6'h08, 8'h2C, "R9 byte0");
    rd_exp(6'h09, 8'h01, "R9 byte1");
    rd_exp(6'h0A, 8'h00, "R9 byte2");
    rd_exp(6'h0B, 8'h00, "R9 byte3");
    wr_b(6'h08, 8'hFF);
    rd_exp(6'h08, 8'h2C, "R9 write ignored");
    ticks(211);
    rd_exp(6'h00, 8'h00, "R10 before toggle");
    ticks(1);
    rd_exp(6'h00, 8'h01, "R10 top bit toggle");
    rd_exp(6'h09, 8'h02, "R9 at 512");
    wr_b(6'h00, 8'h01);
    ticks(512);
    rd_exp(6'h08, 8'h00, "R9 wrap");
    rd_exp(6'h00, 8'h01, "R10 wrap toggle");

    // R7 sleep decode
    wr_b(6'h05, 8'h28);
    check("R7 type2 soft_off", {31'b0, soft_off}, 0);
    check("R7 type2 susp", {31'b0, susp_ram}, 0);
    wr_b(6'h05, 8'h24);
    check("R7 type1 susp", {31'b0, susp_ram}, 1);
    check("R7 type1 soft_off", {31'b0, soft_off}, 0);
    wr_b(6'h05, 8'h20);
    check("R7 type0 soft_off", {31'b0, soft_off}, 1);
    check("R7 susp held", {31'b0, susp_ram}, 1);
    wr_b(6'h05, 8'h00);
    check("R7 soft_off held", {31'b0, soft_off}, 1);

    repeat (2) @(negedge clk);
    check("R1 scoreboard drained", exp_q.size(), 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule